// File: doc/BRIEF.md
# Fail-Safe Reset Pulse Controller

This block gathers reset requests from many parts of a system supply chip and turns each one into a single low pulse on a shared, open-drain system reset line. Every pulse is stretched to a guaranteed minimum length. The length is measured in ticks of a 1 ms timebase and is either short (1 ms) or long (20 ms). A length-control bit holds the choice. Software can write the bit. Whenever the chip sits in its restart or fail-safe mode, the bit is forced to the long setting. A microcontroller that failed to come up after a short pulse therefore gets a long pulse on the next attempt.

The block reads the reset line back through a two-flop synchronizer. A falling edge driven onto the line by something outside the block counts as a reset request of its own. The block's own pulses are not re-detected as outside requests. The cause of the most recent accepted reset is kept in a 4-bit source field for software. When the block leaves power-up reset, it holds the line low until the main supply is reported present. It then releases the line after a short pulse and reports the power-on cause.

Top module: `fs_reset_pulse`

## Requirements
- R1: After `rst`, `rst_pull_low` is 1 and `rst_src` is 0 (power-on). The line stays low as long as `supply_ok` has never been sampled high. Ticks are counted only after the cycle in which `supply_ok` is first sampled high, and the line is released on the second counted tick.
- R2: An accepted event sets `rst_pull_low` to 1 at the clock edge where it is sampled. A tick in that same cycle is not counted. The line is released on the (N+1)-th tick sampled after acceptance, where N is 1 when the effective length bit is 0 and N is 20 when it is 1.
- R3: When neither mode input is high, a cycle with `cfg_we` high loads `cfg_long_wdata` into the length bit. The bit takes effect for events accepted from the next cycle on.
- R4: While `mode_restart` or `mode_failsafe` is high, the length bit is set to 1 and writes are ignored. Events accepted in such a cycle use the long length. The bit stays 1 after the mode inputs drop, until software writes 0.
- R5: Source codes are 0 power-on, 1 low supply, 2 standby overcurrent, 3 auxiliary supply short, 4 flash entry, 5 flash exit, 6 wake-up, 7 fail-safe wake-up, 8 watchdog failure, 9 illegal mode, 10 unserved interrupt, 11 external. Strobe `evt_req[i]` reports code i+1. When several strobes are high together, the lowest index wins, and an external edge has the lowest priority.
- R6: A falling edge on `rst_line_in` is accepted as an event with code 11. A pin that falls between two edges sets `rst_pull_low` at the third rising clock edge after the fall.
- R7: Falling edges on `rst_line_in` are ignored while `rst_pull_low` is 1. They are also ignored from the release of the line until the first tick after that release.
- R8: An event accepted while a pulse is active restarts the full length and replaces the source code.
- R9: `rst_src` changes only in a cycle where an event is accepted.
- R10: The length bit is 0 after `rst`, so the first event after power-on gives a short pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| tick_1ms | input | 1 | One-cycle strobe every millisecond |
| supply_ok | input | 1 | Main regulator output present |
| evt_req | input | 10 | Reset request strobes; bit i reports code i+1 |
| mode_restart | input | 1 | Chip is in restart mode |
| mode_failsafe | input | 1 | Chip is in fail-safe mode |
| cfg_we | input | 1 | Write strobe for the length bit |
| cfg_long_wdata | input | 1 | Length bit write value, 1 = long |
| rst_line_in | input | 1 | Sensed level of the reset line |
| rst_pull_low | output | 1 | 1 = pull the reset line low (open drain) |
| rst_src | output | 4 | Cause code of the latest accepted reset |

## Verification
The hardest case to reach from the ports is an outside falling edge that arrives in the short guard window after the block has released the line and before the next tick. The bench waits for the release, gives the synchronizer a few cycles to see the line high, and then pulls the line low again well before the next tick. It checks that no pulse starts and that the source code is unchanged. It then repeats the pull after the next tick and checks that this one is accepted. A behavioural model of the line, including its open-drain wiring and synchronizer delay, is compared with both outputs on every clock.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NUM_STROBES = 10;
  localparam int SRC_W       = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_POWER_ON     = 4'd0,
    SRC_LOW_SUPPLY   = 4'd1,
    SRC_STBY_OVERCUR = 4'd2,
    SRC_AUX_SHORT    = 4'd3,
    SRC_FLASH_ENTER  = 4'd4,
    SRC_FLASH_LEAVE  = 4'd5,
    SRC_WAKE         = 4'd6,
    SRC_FS_WAKE      = 4'd7,
    SRC_WDOG         = 4'd8,
    SRC_BAD_MODE     = 4'd9,
    SRC_IRQ_TIMEOUT  = 4'd10,
    SRC_EXTERNAL     = 4'd11
  } rst_src_e;
endpackage

// File: rtl/rstc_edge_sync.sv
module rstc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic mask,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign fall = prev_q & ~sync_q[STAGES-1] & ~mask;
endmodule

// File: rtl/rstc_src_pick.sv
module rstc_src_pick
  import rstc_pkg::*;
(
  input  logic [NUM_STROBES-1:0] evt_req,
  input  logic                   ext_fall,
  output logic                   any_evt,
  output rst_src_e               code
);
  always_comb begin
    code = SRC_POWER_ON;
    if (ext_fall) code = SRC_EXTERNAL;
    for (int i = NUM_STROBES - 1; i >= 0; i--) begin
      if (evt_req[i]) code = rst_src_e'(SRC_W'(i + 1));
    end
  end

  assign any_evt = (|evt_req) | ext_fall;
endmodule

// File: rtl/rstc_len_cfg.sv
module rstc_len_cfg (
  input  logic clk,
  input  logic rst,
  input  logic mode_restart,
  input  logic mode_failsafe,
  input  logic cfg_we,
  input  logic cfg_wdata,
  output logic cfg_long_q,
  output logic long_sel
);
  logic force_long;
  assign force_long = mode_restart | mode_failsafe;

  always_ff @(posedge clk) begin
    if (rst)             cfg_long_q <= 1'b0;
    else if (force_long) cfg_long_q <= 1'b1;
    else if (cfg_we)     cfg_long_q <= cfg_wdata;
  end

  assign long_sel = cfg_long_q | force_long;
endmodule

// File: rtl/rstc_pulse_timer.sv
module rstc_pulse_timer #(
  parameter int SHORT_MS = 1,
  parameter int LONG_MS  = 20,
  localparam int CNT_W   = $clog2(LONG_MS + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_ok,
  input  logic accept,
  input  logic long_sel,
  output logic pull_low,
  output logic guard
);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_MS + 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_MS + 1);

  logic [CNT_W-1:0] left_q;
  logic             por_wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_low   <= 1'b1;
      guard      <= 1'b0;
      left_q     <= SHORT_LOAD;
      por_wait_q <= 1'b1;
    end else begin
      if (por_wait_q && supply_ok) por_wait_q <= 1'b0;
      if (accept) begin
        pull_low <= 1'b1;
        guard    <= 1'b0;
        left_q   <= long_sel ? LONG_LOAD : SHORT_LOAD;
      end else if (pull_low) begin
        if (tick && !por_wait_q) begin
          if (left_q == CNT_W'(1)) begin
            pull_low <= 1'b0;
            guard    <= 1'b1;
            left_q   <= '0;
          end else begin
            left_q <= left_q - CNT_W'(1);
          end
        end
      end else if (guard && tick) begin
        guard <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fs_reset_pulse.sv
module fs_reset_pulse
  import rstc_pkg::*;
#(
  parameter int SHORT_MS    = 1,
  parameter int LONG_MS     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick_1ms,
  input  logic                   supply_ok,
  input  logic [NUM_STROBES-1:0] evt_req,
  input  logic                   mode_restart,
  input  logic                   mode_failsafe,
  input  logic                   cfg_we,
  input  logic                   cfg_long_wdata,
  input  logic                   rst_line_in,
  output logic                   rst_pull_low,
  output logic [SRC_W-1:0]       rst_src
);
  logic     ext_fall;
  logic     accept;
  logic     guard;
  logic     long_sel;
  logic     cfg_long_q;
  rst_src_e new_code;
  rst_src_e src_q;

  rstc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (rst_line_in),
    .mask (rst_pull_low | guard),
    .fall (ext_fall)
  );

  rstc_src_pick u_pick (
    .evt_req  (evt_req),
    .ext_fall (ext_fall),
    .any_evt  (accept),
    .code     (new_code)
  );

  rstc_len_cfg u_cfg (
    .clk           (clk),
    .rst           (rst),
    .mode_restart  (mode_restart),
    .mode_failsafe (mode_failsafe),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_long_wdata),
    .cfg_long_q    (cfg_long_q),
    .long_sel      (long_sel)
  );

  rstc_pulse_timer #(.SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_1ms),
    .supply_ok (supply_ok),
    .accept    (accept),
    .long_sel  (long_sel),
    .pull_low  (rst_pull_low),
    .guard     (guard)
  );

  always_ff @(posedge clk) begin
    if (rst)         src_q <= SRC_POWER_ON;
    else if (accept) src_q <= new_code;
  end

  assign rst_src = src_q;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       accept,
  input logic       pull,
  input logic       guard,
  input logic [3:0] src,
  input logic       cfg_long,
  input logic       restart,
  input logic       failsafe,
  input logic       cfg_we,
  input logic       wdata
);
  assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(pull) |-> $past(tick));

  assert_accept_pulls_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> pull);

  assert_rise_needs_event_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pull) |-> $past(accept));

  assert_mode_forces_long_R4: assert property (@(posedge clk) disable iff (rst)
    (restart || failsafe) |=> cfg_long);

  assert_write_loads_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !restart && !failsafe) |=> (cfg_long == $past(wdata)));

  assert_src_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(src));

  assert_guard_released_R7: assert property (@(posedge clk) disable iff (rst)
    guard |-> !pull);
endmodule

bind fs_reset_pulse rstc_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick_1ms),
  .accept   (accept),
  .pull     (rst_pull_low),
  .guard    (guard),
  .src      (rst_src),
  .cfg_long (cfg_long_q),
  .restart  (mode_restart),
  .failsafe (mode_failsafe),
  .cfg_we   (cfg_we),
  .wdata    (cfg_long_wdata)
);

// File: tb/fs_reset_pulse_bench.sv
`timescale 1ns/1ps
module fs_reset_pulse_bench;
  localparam int SHORT    = 1;
  localparam int LONG     = 20;
  localparam int TICK_CYC = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic       tick_1ms = 0;
  logic       supply_ok = 0;
  logic [9:0] evt_req = '0;
  logic       mode_restart = 0, mode_failsafe = 0;
  logic       cfg_we = 0, cfg_long_wdata = 0;
  logic       ext_low = 0;
  logic       rst_line_in;
  logic       rst_pull_low;
  logic [3:0] rst_src;

  int errors = 0, checks = 0, cycles = 0, tick_cnt = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  assign rst_line_in = !(rst_pull_low || ext_low);

  fs_reset_pulse u_fs_reset_pulse (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .supply_ok(supply_ok),
    .evt_req(evt_req), .mode_restart(mode_restart), .mode_failsafe(mode_failsafe),
    .cfg_we(cfg_we), .cfg_long_wdata(cfg_long_wdata), .rst_line_in(rst_line_in),
    .rst_pull_low(rst_pull_low), .rst_src(rst_src)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == TICK_CYC - 1) ? 0 : tick_cnt + 1;
    tick_1ms <= (tick_cnt == TICK_CYC - 1);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Behavioural reference model
  int m_pull, m_guard, m_por, m_left, m_src, m_cfg, m_s1, m_s2, m_prev;
  always @(posedge clk) begin
    int code, line, fall, longsel;
    if (rst) begin
      m_pull <= 1; m_guard <= 0; m_por <= 1; m_left <= SHORT + 1;
      m_src <= 0; m_cfg <= 0; m_s1 <= 1; m_s2 <= 1; m_prev <= 1;
    end else begin
      line = (m_pull != 0 || ext_low) ? 0 : 1;
      fall = (m_prev == 1 && m_s2 == 0 && m_pull == 0 && m_guard == 0) ? 1 : 0;
      code = 0;
      for (int i = 9; i >= 0; i--) if (evt_req[i]) code = i + 1;
      if (code == 0 && fall == 1) code = 11;
      longsel = (m_cfg != 0 || mode_restart || mode_failsafe) ? 1 : 0;
      m_s1 <= line; m_s2 <= m_s1; m_prev <= m_s2;
      if (m_por != 0 && supply_ok) m_por <= 0;
      if (mode_restart || mode_failsafe) m_cfg <= 1;
      else if (cfg_we) m_cfg <= cfg_long_wdata;
      if (code != 0) begin
        m_src <= code; m_pull <= 1; m_guard <= 0;
        m_left <= (longsel != 0 ? LONG : SHORT) + 1;
      end else if (m_pull != 0) begin
        if (tick_1ms && m_por == 0) begin
          if (m_left == 1) begin m_pull <= 0; m_guard <= 1; end
          else m_left <= m_left - 1;
        end
      end else if (m_guard != 0 && tick_1ms) m_guard <= 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk({phase, " model pull"}, int'(rst_pull_low), m_pull);
      chk({phase, " model src R9"}, int'(rst_src), m_src);
    end
  end

  task automatic measure(output int t);
    t = 0;
    while (rst_pull_low) begin
      @(posedge clk);
      if (tick_1ms) t++;
      @(negedge clk);
    end
  endtask

  task automatic fire(logic [9:0] mask);
    @(posedge clk iff tick_1ms);
    @(negedge clk);
    evt_req = mask;
    @(negedge clk);
    evt_req = '0;
  endtask

  task automatic wcfg(logic v);
    @(negedge clk);
    cfg_we = 1; cfg_long_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 pull after reset", int'(rst_pull_low), 1);
    chk("R1 src power-on", int'(rst_src), 0);
    repeat (35) @(negedge clk);
    chk("R1 held while supply absent", int'(rst_pull_low), 1);
    @(posedge clk iff tick_1ms);
    @(negedge clk);
    supply_ok = 1;
    measure(t);
    chk("R1 power-on ticks", t, SHORT + 1);

    phase = "R2";
    fire(10'b0010000000);
    chk("R5 watchdog code", int'(rst_src), 8);
    measure(t);
    chk("R10 R2 short pulse ticks", t, SHORT + 1);
    repeat (5) @(negedge clk);
    chk("R9 src held after pulse", int'(rst_src), 8);

    phase = "R3";
    wcfg(1);
    fire(10'b0000000001);
    chk("R5 low supply code", int'(rst_src), 1);
    measure(t);
    chk("R3 R2 long pulse ticks", t, LONG + 1);
    wcfg(0);
    fire(10'b0000100000);
    measure(t);
    chk("R3 back to short", t, SHORT + 1);

    phase = "R4";
    @(negedge clk);
    mode_restart = 1;
    wcfg(0);
    fire(10'b0000000010);
    measure(t);
    chk("R4 restart forces long", t, LONG + 1);
    mode_restart = 0;
    fire(10'b0000000100);
    measure(t);
    chk("R4 long bit sticky", t, LONG + 1);
    wcfg(0);
    mode_failsafe = 1;
    fire(10'b0001000000);
    chk("R5 fail-safe wake code", int'(rst_src), 7);
    measure(t);
    chk("R4 fail-safe forces long", t, LONG + 1);
    mode_failsafe = 0;
    wcfg(0);

    phase = "R5";
    fire(10'b0010001000);
    chk("R5 lowest index wins", int'(rst_src), 4);
    measure(t);
    fire(10'b1000000000);
    chk("R5 unserved interrupt code", int'(rst_src), 10);
    measure(t);

    phase = "R8";
    wcfg(1);
    fire(10'b0000000001);
    repeat (3) @(posedge clk iff tick_1ms);
    @(negedge clk);
    chk("R8 first pulse active", int'(rst_pull_low), 1);
    evt_req = 10'b0000100000;
    @(negedge clk);
    evt_req = '0;
    chk("R8 newest cause", int'(rst_src), 6);
    measure(t);
    chk("R8 full length restarted", t, LONG + 1);
    wcfg(0);

    phase = "R6";
    @(posedge clk iff tick_1ms);
    @(negedge clk);
    ext_low = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 not yet after two edges", int'(rst_pull_low), 0);
    @(negedge clk);
    chk("R6 pulled at third edge", int'(rst_pull_low), 1);
    chk("R6 external code", int'(rst_src), 11);
    repeat (2) @(negedge clk);
    ext_low = 0;
    measure(t);
    chk("R6 external short pulse", t, SHORT + 1);

    phase = "R7";
    fire(10'b0000000100);
    repeat (3) @(negedge clk);
    ext_low = 1;
    repeat (5) @(negedge clk);
    ext_low = 0;
    measure(t);
    chk("R7 own pulse not retriggered", t, SHORT + 1);
    chk("R7 src kept during pulse", int'(rst_src), 3);
    repeat (4) @(negedge clk);
    ext_low = 1;
    repeat (4) @(negedge clk);
    chk("R7 edge in guard ignored", int'(rst_pull_low), 0);
    ext_low = 0;
    @(negedge clk);
    chk("R7 src unchanged after guard edge", int'(rst_src), 3);
    @(posedge clk iff tick_1ms);
    repeat (2) @(negedge clk);
    phase = "R6";
    ext_low = 1;
    repeat (3) @(negedge clk);
    chk("R6 edge after guard accepted", int'(rst_pull_low), 1);
    chk("R6 code after guard", int'(rst_src), 11);
    ext_low = 0;
    measure(t);
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule